// File: doc/BRIEF.md
# Codec clock and frame generator

This block derives the timing for a serial codec link from one system clock. It makes a master clock for the codec, a bit clock and a frame sync. Each of these has its own programmable divider. The frame sync pulse also has a programmable width and active level.

A role input selects how the block works. In generate role the block runs its dividers, drives the bit clock and the frame sync onto the link, and raises their output enables. In external role the dividers are held in reset and the output enables stay low. The bit clock and frame sync supplied by the external codec are then passed straight to the serial engine.

The serial engine is clocked by the system clock. It uses single-cycle strobes that mark each bit's launch point, its sample point and the start of each frame. Divider, width and polarity settings are captured in shadow copies at frame boundaries. A setting changed in mid-frame therefore cannot cut a clock or sync pulse short.

Top module: `codec_cg_top`

## Requirements
- R1: While running with master divider value D, `mclk_tick_o` pulses once every D+1 clocks. The first pulse comes in the first running cycle. `mclk_o` is high for (D>>1)+1 cycles of each period, starting at the tick. With D=0 it stays high.
- R2: With bit divider value M, each bit lasts 2*(M+1) clocks. `launch_tick_o` pulses in the first cycle of each bit and `sample_tick_o` pulses in the first cycle of its second half. `bclk_o` is at the inverse of `clk_pol_i` for the first M+1 cycles of the bit and equal to `clk_pol_i` for the rest.
- R3: With frame divider value N, a frame lasts N'+1 bits, where N' = N, or 1 when N=0. `frame_start_o` pulses together with the launch strobe of the frame's first bit.
- R4: The frame sync is active during the first W' bits of each frame. W' is `sync_width_i` clamped into the range 1..N'.
- R5: The active level of `sync_o` equals `sync_pol_i`: 1 means active high and 0 means active low. The inactive level is the inverse.
- R6: In the cycle where `frame_start_o` pulses, `sync_o` is already at its active level and `bclk_o` is already at its launch level.
- R7: After reset, or from the second cycle after `gen_en_i` or `gen_mode_i` goes low, the block is idle. In that state `bclk_o` equals `clk_pol_i`, `sync_o` is inactive, `mclk_o` is 0, all strobes are 0 and both output enables are 0.
- R8: With `gen_mode_i`=0, `ser_bclk_o` follows `ext_bclk_i`, `ser_sync_o` follows `ext_sync_i`, and both output enables are 0. While generating, both enables are 1 and the serial outputs carry `bclk_o` and `sync_o`.
- R9: Changes to the bit divider, frame divider, width or polarities made during a frame do not alter the frame in progress. They apply from the next frame onward.
- R10: `frame_start_o` and `bclk_oe_o` are 1 in the first cycle after the clock edge that first samples both `gen_en_i` and `gen_mode_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gen_en_i | input | 1 | Generator enable |
| gen_mode_i | input | 1 | Role: 1 generate, 0 external |
| mclk_div_i | input | MDIV_W | Master clock divider value D |
| bclk_div_i | input | BDIV_W | Bit clock half-period divider value M |
| frame_div_i | input | FDIV_W | Frame length value N (in bits) |
| sync_width_i | input | FDIV_W | Frame sync width (in bits) |
| clk_pol_i | input | 1 | Bit clock polarity: 0 launches on the rising edge |
| sync_pol_i | input | 1 | Frame sync active level |
| ext_bclk_i | input | 1 | Bit clock from the external codec |
| ext_sync_i | input | 1 | Frame sync from the external codec |
| mclk_o | output | 1 | Master clock level |
| mclk_tick_o | output | 1 | Master clock period strobe |
| bclk_o | output | 1 | Generated bit clock level |
| bclk_oe_o | output | 1 | Bit clock output enable |
| sync_o | output | 1 | Generated frame sync level |
| sync_oe_o | output | 1 | Frame sync output enable |
| ser_bclk_o | output | 1 | Bit clock delivered to the serial engine |
| ser_sync_o | output | 1 | Frame sync delivered to the serial engine |
| launch_tick_o | output | 1 | Bit launch strobe |
| sample_tick_o | output | 1 | Bit sample strobe |
| frame_start_o | output | 1 | Frame start strobe |

## Verification
The bench builds the block with MDIV_W=5, BDIV_W=4 and FDIV_W=4, which keeps the longest frame at 512 clocks. At these widths the all-ones value of every field is cheap to reach, and so are the zero values that need clamping and a width above the frame length. Random settings are drawn across each field's whole range and mixed with directed cases. The directed cases cover a divider change in mid-frame, the external role and idle behaviour.

// File: rtl/codec_cg_pkg.sv
package codec_cg_pkg;

  typedef enum logic {
    ROLE_EXT = 1'b0,
    ROLE_GEN = 1'b1
  } role_e;

  typedef struct packed {
    logic clk_pol;
    logic sync_pol;
  } pol_t;

endpackage

// File: rtl/codec_cg_rstsync.sv
module codec_cg_rstsync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];

endmodule

// File: rtl/codec_cg_mclk.sv
module codec_cg_mclk #(
  parameter int DW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [DW-1:0] div_i,
  output logic          mclk_o,
  output logic          tick_o
);

  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] div_q, div_d;
  logic          wrap;

  assign wrap = (cnt_q == div_q);

  always_comb begin
    cnt_d = cnt_q;
    div_d = div_q;
    if (!run_i) begin
      cnt_d = '0;
      div_d = div_i;
    end else if (wrap) begin
      cnt_d = '0;
      div_d = div_i;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_d;
    end
  end

  assign tick_o = run_i && (cnt_q == '0);
  assign mclk_o = run_i && (cnt_q <= (div_q >> 1));

  // R1: the count never leaves the period set by the captured divider
  p_mclk_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= div_q));

  // R1: the period restarts only after a full count
  p_mclk_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wrap) |=> (!run_i || !tick_o));

endmodule

// File: rtl/codec_cg_bitgen.sv
module codec_cg_bitgen
  import codec_cg_pkg::*;
#(
  parameter int BW = 16,
  parameter int FW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [BW-1:0] bdiv_i,
  input  logic [FW-1:0] fdiv_i,
  input  logic [FW-1:0] width_i,
  input  pol_t          pol_i,
  output logic          run_o,
  output logic          bclk_o,
  output logic          sync_o,
  output logic          launch_o,
  output logic          sample_o,
  output logic          frame_start_o
);

  localparam logic [FW-1:0] ONE_F = FW'(1);

  logic          run_q, run_d;
  logic          half_q, half_d;
  logic [BW-1:0] hcnt_q, hcnt_d;
  logic [FW-1:0] bcnt_q, bcnt_d;
  logic [BW-1:0] bdiv_q, bdiv_d;
  logic [FW-1:0] neff_q, neff_d;
  logic [FW-1:0] weff_q, weff_d;
  pol_t          pol_q, pol_d;

  logic [FW-1:0] neff_in, weff_in;
  logic          half_end, bit_end, frame_end, load;
  logic          sync_active;

  // clamp frame length and width while capturing them
  always_comb begin
    neff_in = (fdiv_i == '0) ? ONE_F : fdiv_i;
    if (width_i == '0)          weff_in = ONE_F;
    else if (width_i > neff_in) weff_in = neff_in;
    else                        weff_in = width_i;
  end

  assign half_end  = (hcnt_q == bdiv_q);
  assign bit_end   = half_end && half_q;
  assign frame_end = bit_end && (bcnt_q == neff_q);
  assign load      = !run_q || frame_end;

  always_comb begin
    run_d  = go_i;
    half_d = half_q;
    hcnt_d = hcnt_q;
    bcnt_d = bcnt_q;
    if (!run_q) begin
      half_d = 1'b0;
      hcnt_d = '0;
      bcnt_d = '0;
    end else begin
      if (half_end) begin
        hcnt_d = '0;
        half_d = !half_q;
      end else begin
        hcnt_d = hcnt_q + 1'b1;
      end
      if (bit_end) begin
        bcnt_d = frame_end ? '0 : bcnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    bdiv_d = bdiv_q;
    neff_d = neff_q;
    weff_d = weff_q;
    pol_d  = pol_q;
    if (load) begin
      bdiv_d = bdiv_i;
      neff_d = neff_in;
      weff_d = weff_in;
      pol_d  = pol_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      half_q <= 1'b0;
      hcnt_q <= '0;
      bcnt_q <= '0;
      bdiv_q <= '0;
      neff_q <= ONE_F;
      weff_q <= ONE_F;
      pol_q  <= '0;
    end else begin
      run_q  <= run_d;
      half_q <= half_d;
      hcnt_q <= hcnt_d;
      bcnt_q <= bcnt_d;
      bdiv_q <= bdiv_d;
      neff_q <= neff_d;
      weff_q <= weff_d;
      pol_q  <= pol_d;
    end
  end

  assign sync_active   = run_q && (bcnt_q < weff_q);
  assign run_o         = run_q;
  assign bclk_o        = run_q ? (pol_q.clk_pol ^ !half_q) : pol_q.clk_pol;
  assign sync_o        = sync_active ? pol_q.sync_pol : !pol_q.sync_pol;
  assign launch_o      = run_q && !half_q && (hcnt_q == '0);
  assign sample_o      = run_q && half_q && (hcnt_q == '0);
  assign frame_start_o = launch_o && (bcnt_q == '0);

  // R2: half-bit count bounded by the captured divider
  p_hcnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (hcnt_q <= bdiv_q));

  // R3: bit index bounded by the clamped frame length
  p_bcnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (bcnt_q <= neff_q));

  // R4: captured width lies in 1..frame length
  p_width_clamp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> ((weff_q != '0) && (weff_q <= neff_q)));

  // R6: sync leading edge coincides with the launch level of the first bit
  p_sync_lead_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> ((sync_o == pol_q.sync_pol) && (bclk_o != pol_q.clk_pol)));

  // R9: captured settings hold everywhere inside a frame
  p_cfg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && go_i && !frame_end) |=>
      ($stable(bdiv_q) && $stable(neff_q) && $stable(weff_q) && $stable(pol_q)));

endmodule

// File: rtl/codec_cg_route.sv
module codec_cg_route (
  input  logic gen_mode_i,
  input  logic run_i,
  input  logic int_bclk_i,
  input  logic int_sync_i,
  input  logic ext_bclk_i,
  input  logic ext_sync_i,
  output logic bclk_oe_o,
  output logic sync_oe_o,
  output logic ser_bclk_o,
  output logic ser_sync_o
);

  always_comb begin
    bclk_oe_o = run_i;
    sync_oe_o = run_i;
    if (gen_mode_i) begin
      ser_bclk_o = int_bclk_i;
      ser_sync_o = int_sync_i;
    end else begin
      ser_bclk_o = ext_bclk_i;
      ser_sync_o = ext_sync_i;
    end
  end

endmodule

// File: rtl/codec_cg_top.sv
module codec_cg_top
  import codec_cg_pkg::*;
#(
  parameter int MDIV_W = 9,
  parameter int BDIV_W = 16,
  parameter int FDIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gen_en_i,
  input  logic              gen_mode_i,
  input  logic [MDIV_W-1:0] mclk_div_i,
  input  logic [BDIV_W-1:0] bclk_div_i,
  input  logic [FDIV_W-1:0] frame_div_i,
  input  logic [FDIV_W-1:0] sync_width_i,
  input  logic              clk_pol_i,
  input  logic              sync_pol_i,
  input  logic              ext_bclk_i,
  input  logic              ext_sync_i,
  output logic              mclk_o,
  output logic              mclk_tick_o,
  output logic              bclk_o,
  output logic              bclk_oe_o,
  output logic              sync_o,
  output logic              sync_oe_o,
  output logic              ser_bclk_o,
  output logic              ser_sync_o,
  output logic              launch_tick_o,
  output logic              sample_tick_o,
  output logic              frame_start_o
);

  logic  rst_n;
  role_e role;
  pol_t  pol;
  logic  go;
  logic  run;

  assign role = role_e'(gen_mode_i);
  assign pol  = '{clk_pol: clk_pol_i, sync_pol: sync_pol_i};
  assign go   = gen_en_i && (role == ROLE_GEN);

  codec_cg_rstsync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  codec_cg_bitgen #(
    .BW (BDIV_W),
    .FW (FDIV_W)
  ) u_bit (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .go_i          (go),
    .bdiv_i        (bclk_div_i),
    .fdiv_i        (frame_div_i),
    .width_i       (sync_width_i),
    .pol_i         (pol),
    .run_o         (run),
    .bclk_o        (bclk_o),
    .sync_o        (sync_o),
    .launch_o      (launch_tick_o),
    .sample_o      (sample_tick_o),
    .frame_start_o (frame_start_o)
  );

  codec_cg_mclk #(
    .DW (MDIV_W)
  ) u_mclk (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .run_i  (run),
    .div_i  (mclk_div_i),
    .mclk_o (mclk_o),
    .tick_o (mclk_tick_o)
  );

  codec_cg_route u_route (
    .gen_mode_i (gen_mode_i),
    .run_i      (run),
    .int_bclk_i (bclk_o),
    .int_sync_i (sync_o),
    .ext_bclk_i (ext_bclk_i),
    .ext_sync_i (ext_sync_i),
    .bclk_oe_o  (bclk_oe_o),
    .sync_oe_o  (sync_oe_o),
    .ser_bclk_o (ser_bclk_o),
    .ser_sync_o (ser_sync_o)
  );

  // R8: external role never drives the link
  p_oe_role_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$past(gen_mode_i) |-> (!bclk_oe_o && !sync_oe_o));

  // R7: a stopped generator emits no strobes
  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$past(go) |-> (!frame_start_o && !mclk_tick_o && !launch_tick_o && !mclk_o));

  // R10: starting always opens with a frame start
  p_start_frame_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (go && !run) |=> (frame_start_o && mclk_tick_o));

endmodule

// File: tb/codec_cg_top_tb_top.sv
module codec_cg_top_tb_top;

  localparam int MW = 5;
  localparam int BW = 4;
  localparam int FW = 4;

  logic clk_i = 1'b0;
  always #10 clk_i = ~clk_i;

  logic          rst_ni;
  logic          gen_en, gen_mode;
  logic [MW-1:0] mclk_div;
  logic [BW-1:0] bclk_div;
  logic [FW-1:0] frame_div, sync_width;
  logic          clk_pol, sync_pol, ext_bclk, ext_sync;
  logic mclk_o, mclk_tick_o, bclk_o, bclk_oe_o, sync_o, sync_oe_o;
  logic ser_bclk_o, ser_sync_o, launch_tick_o, sample_tick_o, frame_start_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  codec_cg_top #(.MDIV_W(MW), .BDIV_W(BW), .FDIV_W(FW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .gen_en_i(gen_en), .gen_mode_i(gen_mode),
    .mclk_div_i(mclk_div), .bclk_div_i(bclk_div), .frame_div_i(frame_div),
    .sync_width_i(sync_width), .clk_pol_i(clk_pol), .sync_pol_i(sync_pol),
    .ext_bclk_i(ext_bclk), .ext_sync_i(ext_sync), .mclk_o(mclk_o),
    .mclk_tick_o(mclk_tick_o), .bclk_o(bclk_o), .bclk_oe_o(bclk_oe_o),
    .sync_o(sync_o), .sync_oe_o(sync_oe_o), .ser_bclk_o(ser_bclk_o),
    .ser_sync_o(ser_sync_o), .launch_tick_o(launch_tick_o),
    .sample_tick_o(sample_tick_o), .frame_start_o(frame_start_o)
  );

  function automatic int f_neff(int n);
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int f_weff(int w, int n);
    int ne = f_neff(n);
    if (w < 1) return 1;
    if (w > ne) return ne;
    return w;
  endfunction

  function automatic int f_frame_len(int m, int n);
    return (f_neff(n) + 1) * 2 * (m + 1);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive_cfg(int d, int m, int n, int w, bit cp, bit sp);
    mclk_div   = MW'(d);
    bclk_div   = BW'(m);
    frame_div  = FW'(n);
    sync_width = FW'(w);
    clk_pol    = cp;
    sync_pol   = sp;
  endtask

  task automatic stop_gen();
    @(negedge clk_i);
    gen_en = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic start_gen();
    @(negedge clk_i);
    gen_en   = 1'b1;
    gen_mode = 1'b1;
    @(negedge clk_i);
    chk("R10", "frame_start after enable", int'(frame_start_o), 1);
    chk("R10", "bclk_oe after enable", int'(bclk_oe_o), 1);
    chk("R1", "mclk_tick after enable", int'(mclk_tick_o), 1);
  endtask

  task automatic idle_check(bit cp, bit sp, string req);
    int bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (bclk_o != cp || sync_o == sp || mclk_o || mclk_tick_o || launch_tick_o ||
          sample_tick_o || frame_start_o || bclk_oe_o || sync_oe_o) bad++;
    end
    chk(req, "idle cycles with activity", bad, 0);
  endtask

  task automatic wait_fs(output int k);
    k = 0;
    do begin
      @(negedge clk_i);
      k++;
    end while (!frame_start_o && k < 4000);
  endtask

  task automatic measure_frame(int m, int n, int w, bit cp, bit sp, string req);
    int k, len, lau, sam, lvl, act, ser_bad;
    wait_fs(k);
    chk("R6", "sync active at frame start", int'(sync_o == sp), 1);
    chk("R6", "bclk launch level at frame start", int'(bclk_o != cp), 1);
    len = 0; lau = 0; sam = 0; lvl = 0; act = 0; ser_bad = 0;
    do begin
      len++;
      lau += int'(launch_tick_o);
      sam += int'(sample_tick_o);
      lvl += int'(bclk_o != cp);
      act += int'(sync_o == sp);
      if (ser_bclk_o != bclk_o || ser_sync_o != sync_o || !bclk_oe_o || !sync_oe_o) ser_bad++;
      @(negedge clk_i);
    end while (!frame_start_o && len < 4000);
    chk({req, "/R3"}, "frame length", len, f_frame_len(m, n));
    chk({req, "/R2"}, "launch strobes", lau, f_neff(n) + 1);
    chk({req, "/R2"}, "sample strobes", sam, f_neff(n) + 1);
    chk({req, "/R2"}, "launch-level cycles", lvl, (f_neff(n) + 1) * (m + 1));
    chk({req, "/R4/R5"}, "sync active cycles", act, f_weff(w, n) * 2 * (m + 1));
    chk("R8", "serial path mismatches", ser_bad, 0);
  endtask

  task automatic measure_mclk(int d);
    int k, len, hi;
    k = 0;
    do begin
      @(negedge clk_i);
      k++;
    end while (!mclk_tick_o && k < 200);
    len = 0; hi = 0;
    do begin
      len++;
      hi += int'(mclk_o);
      @(negedge clk_i);
    end while (!mclk_tick_o && len < 200);
    chk("R1", "mclk period", len, d + 1);
    chk("R1", "mclk high cycles", hi, (d >> 1) + 1);
  endtask

  task automatic run_case(int d, int m, int n, int w, bit cp, bit sp, string req);
    stop_gen();
    drive_cfg(d, m, n, w, cp, sp);
    start_gen();
    measure_frame(m, n, w, cp, sp, req);
    measure_mclk(d);
  endtask

  initial begin
    int k;
    void'($urandom(32'd20240611));
    rst_ni = 1'b0; gen_en = 1'b0; gen_mode = 1'b0;
    ext_bclk = 1'b0; ext_sync = 1'b0;
    drive_cfg(0, 0, 0, 0, 1'b0, 1'b0);
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    idle_check(1'b0, 1'b0, "R7 reset");

    // directed cases
    run_case(3, 2, 5, 2, 1'b0, 1'b0, "R2 basic");
    stop_gen();
    clk_pol = 1'b1; sync_pol = 1'b1;
    repeat (2) @(negedge clk_i);
    idle_check(1'b1, 1'b1, "R7 disabled");
    run_case(0, 0, 0, 0, 1'b1, 1'b1, "R3 zero fields");
    run_case(31, 15, 15, 15, 1'b0, 1'b1, "R4 all ones");
    run_case(6, 1, 3, 9, 1'b1, 1'b0, "R4 wide clamp");

    // R9: change everything three cycles into a frame
    run_case(2, 1, 4, 2, 1'b0, 1'b0, "R9 before");
    wait_fs(k);
    repeat (3) @(negedge clk_i);
    drive_cfg(2, 3, 2, 1, 1'b1, 1'b1);
    wait_fs(k);
    chk("R9", "old frame completes", k, f_frame_len(1, 4) - 3);
    measure_frame(3, 2, 1, 1'b1, 1'b1, "R9 after");

    // R8: external role
    @(negedge clk_i);
    gen_mode = 1'b0;
    gen_en   = 1'b1;
    repeat (2) @(negedge clk_i);
    begin
      int bad = 0;
      for (int i = 0; i < 16; i++) begin
        ext_bclk = 1'($urandom);
        ext_sync = 1'($urandom);
        #2;
        if (ser_bclk_o != ext_bclk || ser_sync_o != ext_sync || bclk_oe_o || sync_oe_o) bad++;
        @(negedge clk_i);
        if (frame_start_o || mclk_tick_o) bad++;
      end
      chk("R8", "external role pass-through errors", bad, 0);
    end
    gen_en = 1'b0;

    // constrained random cases
    for (int i = 0; i < 12; i++) begin
      run_case(int'($urandom_range(0, 31)), int'($urandom_range(0, 15)),
               int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
               1'($urandom), 1'($urandom), "R2 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule